// File: doc/BRIEF.md
# Memory Micro-op Port Steering

This block sits between the scheduler and the memory execution pipes. Each cycle it looks at a small set of ready memory micro-ops and places each one on an execution port, or tells its source to hold it. Three kinds of micro-op are handled: loads, store-address operations and store-data operations. The block drives four ports. Two are general load pipes with full address generators. One is a store-address pipe that can only handle addressing modes without an index register. The last is the only pipe that accepts store data.

Each input carries a kind code, a flag for an indexed addressing mode, a flag for a 256-bit operand, and an opaque tag. The chosen port receives the tag together with the kind and flags. A 256-bit load keeps its load pipe busy for one extra cycle. During that extra cycle the pipe's address generator can still take a store-address micro-op. A 256-bit store-data operation blocks the store-data pipe for the extra cycle. Port choice is combinational from the inputs and the busy state, which is registered.

Top module: `mport_steer`

## Requirements
- R1: A load (kind code 0) issues only on load port A (index 0) or load port B (index 1). Port A is tried first, then port B. Port A is skipped while it is in the extra cycle of a wide load.
- R2: A store-data op (kind code 2) issues only on the store-data port (index 3), so at most one is accepted per cycle.
- R3: A store-address op (kind code 1) with the indexed flag set never goes to the simple store-address port (index 2). It takes port A, then port B, and otherwise stalls.
- R4: A store-address op without the indexed flag takes port 2 first, then port A, then port B. Up to three such ops can issue in one cycle.
- R5: Two loads, one non-indexed store-address op and one store-data op presented together all issue in the same cycle.
- R6: A load issued with the wide flag makes its load port refuse loads in the following cycle. A store-address op may still use that port in that cycle.
- R7: A store-data op issued with the wide flag makes the store-data port refuse all ops in the following cycle.
- R8: Inputs are served oldest first, and input 0 is the oldest. stall_o[i] is high exactly when input i is valid and got no port. Younger inputs may use ports left over by a stalled older one.
- R9: Each port that is valid presents the tag, kind, indexed flag and wide flag of the input placed on it.
- R10: After reset no port is held busy. With no valid inputs, no port is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | N_IN | Per-input valid |
| in_kind_i | input | N_IN x 2 | Kind: 0 load, 1 store-address, 2 store-data |
| in_idx_i | input | N_IN | Addressing mode uses an index register |
| in_wide_i | input | N_IN | 256-bit operand |
| in_tag_i | input | N_IN x TAG_W | Opaque micro-op tag |
| stall_o | output | N_IN | Input valid but not placed this cycle |
| port_vld_o | output | 4 | Port carries an op (0 A, 1 B, 2 store-address, 3 store-data) |
| port_kind_o | output | 4 x 2 | Kind of the op on each port |
| port_idx_o | output | 4 | Indexed flag of the op on each port |
| port_wide_o | output | 4 | Wide flag of the op on each port |
| port_tag_o | output | 4 x TAG_W | Tag of the op on each port |

## Verification
Two functions can land in the same cycle: the extra busy cycle left by a wide load, and fresh placement of new ops on that same load port. The bench provokes this in two ways. A directed sequence issues a wide load and then offers a load and an indexed store-address op together in the next cycle. A sweep of every kind/flag combination over four inputs, applied back to back, creates many more such overlaps. The outcome is judged against a reference model in the bench. The model tracks the busy state from its own predicted grants, so the load must move to port B while the store-address op still gets port A.

// File: rtl/mport_pkg.sv
package mport_pkg;
  typedef enum logic [1:0] {
    K_LD  = 2'd0,
    K_STA = 2'd1,
    K_STD = 2'd2,
    K_RSV = 2'd3
  } uop_kind_e;

  localparam int NPORT = 4;
  localparam int P_LA  = 0;
  localparam int P_LB  = 1;
  localparam int P_SA  = 2;
  localparam int P_SD  = 3;
endpackage

// File: rtl/mport_hold.sv
module mport_hold #(
  parameter int EXTRA = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic occupy_i,
  output logic hold_o
);
  localparam int CW = (EXTRA < 2) ? 1 : $clog2(EXTRA + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (occupy_i)         cnt_q <= CW'(EXTRA);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);
endmodule

// File: rtl/mport_pick.sv
module mport_pick
  import mport_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_IN-1:0]             vld_i,
  input  logic [N_IN-1:0][1:0]        kind_i,
  input  logic [N_IN-1:0]             idx_i,
  input  logic [NPORT-1:0]            hold_i,
  output logic [NPORT-1:0]            used_o,
  output logic [NPORT-1:0][IDX_W-1:0] src_o,
  output logic [N_IN-1:0]             won_o
);
  // lower input index = older = served first
  always_comb begin
    used_o = '0;
    src_o  = '0;
    won_o  = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (vld_i[i]) begin
        case (uop_kind_e'(kind_i[i]))
          K_LD: begin
            if (!used_o[P_LA] && !hold_i[P_LA]) begin
              used_o[P_LA] = 1'b1; src_o[P_LA] = IDX_W'(i); won_o[i] = 1'b1;
            end else if (!used_o[P_LB] && !hold_i[P_LB]) begin
              used_o[P_LB] = 1'b1; src_o[P_LB] = IDX_W'(i); won_o[i] = 1'b1;
            end
          end
          K_STD: begin
            if (!used_o[P_SD] && !hold_i[P_SD]) begin
              used_o[P_SD] = 1'b1; src_o[P_SD] = IDX_W'(i); won_o[i] = 1'b1;
            end
          end
          K_STA: begin
            // held load ports keep a free address generator
            if (!idx_i[i] && !used_o[P_SA] && !hold_i[P_SA]) begin
              used_o[P_SA] = 1'b1; src_o[P_SA] = IDX_W'(i); won_o[i] = 1'b1;
            end else if (!used_o[P_LA]) begin
              used_o[P_LA] = 1'b1; src_o[P_LA] = IDX_W'(i); won_o[i] = 1'b1;
            end else if (!used_o[P_LB]) begin
              used_o[P_LB] = 1'b1; src_o[P_LB] = IDX_W'(i); won_o[i] = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mport_steer.sv
module mport_steer
  import mport_pkg::*;
#(
  parameter int N_IN      = 4,
  parameter int TAG_W     = 6,
  parameter int WIDE_XTRA = 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_IN-1:0]              in_vld_i,
  input  logic [N_IN-1:0][1:0]         in_kind_i,
  input  logic [N_IN-1:0]              in_idx_i,
  input  logic [N_IN-1:0]              in_wide_i,
  input  logic [N_IN-1:0][TAG_W-1:0]   in_tag_i,
  output logic [N_IN-1:0]              stall_o,
  output logic [3:0]                   port_vld_o,
  output logic [3:0][1:0]              port_kind_o,
  output logic [3:0]                   port_idx_o,
  output logic [3:0]                   port_wide_o,
  output logic [3:0][TAG_W-1:0]        port_tag_o
);
  localparam int IDX_W = (N_IN < 2) ? 1 : $clog2(N_IN);

  logic [NPORT-1:0]            hold;
  logic [NPORT-1:0]            used;
  logic [NPORT-1:0][IDX_W-1:0] src;
  logic [N_IN-1:0]             won;

  mport_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pick (
    .vld_i  (in_vld_i),
    .kind_i (in_kind_i),
    .idx_i  (in_idx_i),
    .hold_i (hold),
    .used_o (used),
    .src_o  (src),
    .won_o  (won)
  );

  assign stall_o = in_vld_i & ~won;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_vld_o[p]  = used[p];
    assign port_kind_o[p] = used[p] ? in_kind_i[src[p]] : 2'd0;
    assign port_idx_o[p]  = used[p] & in_idx_i[src[p]];
    assign port_wide_o[p] = used[p] & in_wide_i[src[p]];
    assign port_tag_o[p]  = used[p] ? in_tag_i[src[p]] : '0;

    if (p == P_SA) begin : g_nohold
      assign hold[p] = 1'b0;
    end else begin : g_hold
      logic occupy;
      // address-only ops never extend a port
      assign occupy = used[p] & in_wide_i[src[p]] &
                      (in_kind_i[src[p]] != 2'(K_STA));
      mport_hold #(.EXTRA(WIDE_XTRA)) u_hold (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .occupy_i (occupy),
        .hold_o   (hold[p])
      );
    end
  end
endmodule

// File: rtl/mport_steer_chk.sv
module mport_steer_chk
  import mport_pkg::*;
#(
  parameter int N_IN = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_IN-1:0] in_vld_i,
  input logic [N_IN-1:0] stall_o,
  input logic [3:0]      port_vld_o,
  input logic [3:0][1:0] port_kind_o,
  input logic [3:0]      port_idx_o,
  input logic [3:0]      port_wide_o
);
  p_la_kind_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_vld_o[P_LA] |-> port_kind_o[P_LA] != 2'(K_STD));
  p_lb_kind_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_vld_o[P_LB] |-> port_kind_o[P_LB] != 2'(K_STD));
  p_sd_kind_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_vld_o[P_SD] |-> port_kind_o[P_SD] == 2'(K_STD));
  p_sa_simple_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_vld_o[P_SA] |-> (port_kind_o[P_SA] == 2'(K_STA) && !port_idx_o[P_SA]));
  p_sa_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_vld_o[P_LA] && port_kind_o[P_LA] == 2'(K_STA) && !port_idx_o[P_LA])
    |-> port_vld_o[P_SA]);
  p_la_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_vld_o[P_LA] && port_wide_o[P_LA] && port_kind_o[P_LA] == 2'(K_LD))
    |=> !(port_vld_o[P_LA] && port_kind_o[P_LA] == 2'(K_LD)));
  p_lb_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_vld_o[P_LB] && port_wide_o[P_LB] && port_kind_o[P_LB] == 2'(K_LD))
    |=> !(port_vld_o[P_LB] && port_kind_o[P_LB] == 2'(K_LD)));
  p_sd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_vld_o[P_SD] && port_wide_o[P_SD]) |=> !port_vld_o[P_SD]);
  p_stall_vld_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o & ~in_vld_i) == '0);
  p_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(port_vld_o) + $countones(stall_o) == $countones(in_vld_i));
endmodule

bind mport_steer mport_steer_chk #(.N_IN(N_IN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_vld_i    (in_vld_i),
  .stall_o     (stall_o),
  .port_vld_o  (port_vld_o),
  .port_kind_o (port_kind_o),
  .port_idx_o  (port_idx_o),
  .port_wide_o (port_wide_o)
);

// File: tb/mport_steer_test.sv
module mport_steer_test;
  localparam int CLK_P = 10;
  localparam int N_IN  = 4;
  localparam int TAG_W = 6;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic [N_IN-1:0]            in_vld;
  logic [N_IN-1:0][1:0]       in_kind;
  logic [N_IN-1:0]            in_idx;
  logic [N_IN-1:0]            in_wide;
  logic [N_IN-1:0][TAG_W-1:0] in_tag;
  logic [N_IN-1:0]            stall;
  logic [3:0]                 p_vld;
  logic [3:0][1:0]            p_kind;
  logic [3:0]                 p_idx;
  logic [3:0]                 p_wide;
  logic [3:0][TAG_W-1:0]      p_tag;

  mport_steer #(.N_IN(N_IN), .TAG_W(TAG_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_vld_i(in_vld), .in_kind_i(in_kind), .in_idx_i(in_idx),
    .in_wide_i(in_wide), .in_tag_i(in_tag),
    .stall_o(stall), .port_vld_o(p_vld), .port_kind_o(p_kind),
    .port_idx_o(p_idx), .port_wide_o(p_wide), .port_tag_o(p_tag)
  );

  always #(CLK_P/2) clk = ~clk;

  int  n_run = 0;
  int  n_fail = 0;
  int  seq = 0;
  bit  done = 0;
  bit  mh [4];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string preq(int p);
    case (p)
      0, 1:    return "R1";
      2:       return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic clr();
    in_vld = '0; in_kind = '0; in_idx = '0; in_wide = '0; in_tag = '0;
    seq++;
  endtask

  task automatic put(int i, int k, bit ix, bit w);
    in_vld[i]  = 1'b1;
    in_kind[i] = 2'(k);
    in_idx[i]  = ix;
    in_wide[i] = w;
    in_tag[i]  = TAG_W'(i + 4 * (seq % 16));
  endtask

  // reference placement from the requirements; mh tracks busy state
  task automatic model_check();
    bit u [4];
    int s [4];
    bit w [N_IN];
    for (int p = 0; p < 4; p++) begin u[p] = 0; s[p] = 0; end
    for (int i = 0; i < N_IN; i++) begin
      w[i] = 0;
      if (in_vld[i]) begin
        if (in_kind[i] == 2'd0) begin
          if (!u[0] && !mh[0]) begin u[0] = 1; s[0] = i; w[i] = 1; end
          else if (!u[1] && !mh[1]) begin u[1] = 1; s[1] = i; w[i] = 1; end
        end else if (in_kind[i] == 2'd2) begin
          if (!u[3] && !mh[3]) begin u[3] = 1; s[3] = i; w[i] = 1; end
        end else if (in_kind[i] == 2'd1) begin
          if (!in_idx[i] && !u[2]) begin u[2] = 1; s[2] = i; w[i] = 1; end
          else if (!u[0]) begin u[0] = 1; s[0] = i; w[i] = 1; end
          else if (!u[1]) begin u[1] = 1; s[1] = i; w[i] = 1; end
        end
      end
    end
    for (int p = 0; p < 4; p++) begin
      chk(p_vld[p] == u[p], preq(p), $sformatf("port%0d vld", p), int'(p_vld[p]), int'(u[p]));
      if (u[p] && p_vld[p]) begin
        chk(p_tag[p] == in_tag[s[p]], "R9", $sformatf("port%0d tag", p),
            int'(p_tag[p]), int'(in_tag[s[p]]));
        chk(p_kind[p] == in_kind[s[p]] && p_wide[p] == in_wide[s[p]] &&
            p_idx[p] == in_idx[s[p]], "R9", $sformatf("port%0d fields", p),
            int'({p_kind[p], p_idx[p], p_wide[p]}),
            int'({in_kind[s[p]], in_idx[s[p]], in_wide[s[p]]}));
      end
    end
    for (int i = 0; i < N_IN; i++)
      chk(stall[i] == (in_vld[i] && !w[i]), "R8", $sformatf("stall%0d", i),
          int'(stall[i]), int'(in_vld[i] && !w[i]));
    for (int p = 0; p < 4; p++)
      mh[p] = u[p] && in_wide[s[p]] && (in_kind[s[p]] != 2'd1);
  endtask

  // drive after an edge, judge just before the next edge
  task automatic step_begin();
    @(posedge clk); #1;
    clr();
  endtask

  task automatic step_end();
    #(CLK_P - 3);
    model_check();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++) mh[p] = 0;
    clr();
    repeat (3) @(posedge clk);
    #1;
    chk(p_vld == 4'b0, "R10", "ports idle in reset", int'(p_vld), 0);
    rst_n = 1'b1;

    // R10: no port busy after reset, load lands on A
    step_begin(); put(0, 0, 0, 0); step_end();
    chk(p_vld == 4'b0001 && p_tag[0] == in_tag[0], "R10", "load after reset", int'(p_vld), 1);

    // R5: peak mix
    step_begin(); put(0, 0, 0, 0); put(1, 0, 1, 0); put(2, 1, 0, 0); put(3, 2, 0, 0); step_end();
    chk(p_vld == 4'b1111 && stall == '0, "R5", "peak issue", int'(p_vld), 15);

    // R3: indexed store-address avoids port 2
    step_begin(); put(0, 1, 1, 0); put(1, 1, 1, 0); put(2, 1, 1, 0); step_end();
    chk(p_vld == 4'b0011 && stall == 4'b0100, "R3", "indexed sta", int'({stall, p_vld}), 'h43);

    // R4: simple store-address fills 2, A, B
    step_begin(); put(0, 1, 0, 0); put(1, 1, 0, 0); put(2, 1, 0, 0); put(3, 1, 0, 0); step_end();
    chk(p_vld == 4'b0111 && p_tag[2] == in_tag[0] && stall == 4'b1000, "R4", "three sta",
        int'({stall, p_vld}), 'h87);

    // R6: wide load, then load + indexed sta share next cycle
    step_begin(); put(0, 0, 0, 1); step_end();
    chk(p_vld == 4'b0001, "R6", "wide load on A", int'(p_vld), 1);
    step_begin(); put(0, 0, 0, 0); put(1, 1, 1, 0); step_end();
    chk(p_vld == 4'b0011 && p_tag[1] == in_tag[0] && p_tag[0] == in_tag[1], "R6",
        "held A takes sta", int'(p_tag[0]), int'(in_tag[1]));

    // R7: wide store-data blocks next cycle
    step_begin(); put(0, 2, 0, 1); step_end();
    step_begin(); put(0, 2, 0, 0); step_end();
    chk(stall[0] && !p_vld[3], "R7", "std blocked", int'(stall[0]), 1);
    step_begin(); put(0, 2, 0, 0); step_end();
    chk(p_vld[3] && !stall[0], "R7", "std after hold", int'(p_vld[3]), 1);

    // R8: younger takes leftover ports
    step_begin(); put(0, 2, 0, 0); put(1, 2, 0, 0); put(2, 0, 0, 0); step_end();
    chk(stall == 4'b0010 && p_vld == 4'b1001, "R8", "younger bypass", int'({stall, p_vld}), 'h29);

    // exhaustive sweep: each input invalid or one of 12 kind/flag combos
    for (int c = 0; c < 28561; c++) begin
      step_begin();
      for (int i = 0; i < N_IN; i++) begin
        int d = (c / (13 ** i)) % 13;
        if (d != 0) put(i, (d - 1) % 3, ((d - 1) / 3) % 2 == 1, (d - 1) / 6 == 1);
      end
      step_end();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule